// File: doc/BRIEF.md
# Bypassable Gamma Lookup Table

This block remaps one video channel through a programmable table, typically loaded with a gamma curve. Each clock a 13-bit sample enters; its upper 10 bits select one of 1024 stored 13-bit words. When the table is switched on, that word leaves as the output sample. When it is switched off, the incoming sample leaves unchanged.

In both cases the sample takes exactly two clocks to cross the stage. Turning the table on or off therefore never moves a channel in time relative to its neighbours.

A host loads entries through a separate write port (address, data, strobe). It may do so while samples stream through the datapath. The enable travels alongside each sample, so the mode can change from one sample to the next without dropping or repeating a sample.

Top module: `gamma_lut`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dout` becomes 0 after that edge.
- R2: With `lut_en` high alongside sample `din`, `dout` two rising edges later equals the table word at address `din[12:3]`.
- R3: With `lut_en` low alongside sample `din`, `dout` two rising edges later equals `din` bit for bit.
- R4: `lut_en` is sampled together with each sample. Toggling it between consecutive samples switches mode per sample, with no gap or repeated sample at `dout`.
- R5: A host write at one rising edge is returned by a lookup whose sample is presented at the next rising edge.
- R6: When a write and a lookup hit the same entry at the same edge, the lookup returns the word held before that write.
- R7: Host writes update the table whether `lut_en` is high or low.
- R8: The low 3 bits of `din` have no effect on the enabled output; only `din[12:3]` addresses the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lut_en | input | 1 | Table enable, travels with `din` |
| din | input | 13 | Input sample, two's complement |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 10 | Host write entry index |
| wr_data | input | 13 | Host write word |
| dout | output | 13 | Output sample, two cycles after `din` |

## Verification
The bench uses the default widths: 13-bit samples and a 10-bit address. With these it can load all 1024 entries and then read any of them back. Write addresses are often biased toward the address of the current sample, which makes same-entry write and read collisions and write-then-read back-to-back cases frequent. Random per-sample enable toggling exercises mode switches at every position in the pipeline.

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int DATA_W = 13,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lut_en,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] table_q [DEPTH];
  logic [DATA_W-1:0] rd_q, smp_q, dout_q;
  logic              en_q;
  wire  [ADDR_W-1:0] rd_addr = din[DATA_W-1 -: ADDR_W];

  always_ff @(posedge clk)
    if (wr_en) table_q[wr_addr] <= wr_data;

  // Nonblocking read sees the pre-write word on a same-edge collision.
  always_ff @(posedge clk)
    rd_q <= table_q[rd_addr];

  always_ff @(posedge clk)
    if (rst) begin
      smp_q  <= '0;
      en_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      smp_q  <= din;
      en_q   <= lut_en;
      dout_q <= en_q ? rd_q : smp_q;
    end

  assign dout = dout_q;

  // Edges since reset, saturating, so checks never reach before reset.
  logic [1:0] age;
  always_ff @(posedge clk)
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  wire warm = (age == 2'd3);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> dout == '0);

  assert_bypass_pass_R3: assert property (@(posedge clk) disable iff (rst)
    warm && !$past(lut_en, 2) |-> dout == $past(din, 2));

  assert_write_visible_R5: assert property (@(posedge clk) disable iff (rst)
    warm && $past(lut_en, 2) && $past(wr_en, 3) && !$past(wr_en, 2)
      && $past(wr_addr, 3) == $past(din[DATA_W-1 -: ADDR_W], 2)
    |-> dout == $past(wr_data, 3));

  assert_collide_old_R6: assert property (@(posedge clk) disable iff (rst)
    warm && $past(lut_en, 2) && $past(wr_en, 3) && $past(wr_en, 2)
      && $past(wr_addr, 3) == $past(din[DATA_W-1 -: ADDR_W], 2)
      && $past(wr_addr, 2) == $past(wr_addr, 3)
    |-> dout == $past(wr_data, 3));
endmodule

// File: tb/gamma_lut_test.sv
`timescale 1ns/1ps
module gamma_lut_test;
  localparam int DW = 13;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lut_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dout;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] model [1<<AW];
  logic          v1 = 1'b0, v2 = 1'b0;
  logic [DW-1:0] e1 = '0, e2 = '0;
  string         t1 = "", t2 = "";

  gamma_lut uut (.clk(clk), .rst(rst), .lut_en(lut_en), .din(din),
                 .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout));

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] expect_out(input logic en, input logic [DW-1:0] d);
    return en ? model[d[DW-1 -: AW]] : d;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [DW-1:0] d, input logic we,
                      input logic [AW-1:0] wa, input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    if (v2) check(t2, dout, e2);
    v2 = v1; e2 = e1; t2 = t1;
    v1 = 1'b1; e1 = expect_out(en, d); t1 = tag;
    if (we) model[wa] = wd;
    lut_en = en; din = d; wr_en = we; wr_addr = wa; wr_data = wd;
  endtask

  task automatic flush();
    step(1'b0, '0, 1'b0, '0, '0, "R3");
    step(1'b0, '0, 1'b0, '0, '0, "R3");
    step(1'b0, '0, 1'b0, '0, '0, "R3");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; v1 = 1'b0; v2 = 1'b0;
    lut_en = 1'b0; wr_en = 1'b0; din = 13'h1abc;
    @(negedge clk);
    check("R1", dout, '0);
    @(negedge clk);
    check("R1", dout, '0);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // Load the whole table in bypass while bypass samples stream (R7, R3).
    for (int i = 0; i < (1<<AW); i++)
      step(1'b0, DW'($urandom), 1'b1, AW'(i), DW'($urandom), "R3");
    flush();

    // R7: entry written in bypass is returned once enabled.
    step(1'b0, 13'h0005, 1'b1, 10'h155, 13'h1234, "R3");
    step(1'b1, {10'h155, 3'b000}, 1'b0, '0, '0, "R7");
    // R5: write then lookup on the very next edge.
    step(1'b1, 13'h0000, 1'b1, 10'h0a0, 13'h0f0f, "R2");
    step(1'b1, {10'h0a0, 3'b111}, 1'b0, '0, '0, "R5");
    // R6: same-edge collision returns old word, following lookup returns new.
    step(1'b1, {10'h3ff, 3'b010}, 1'b1, 10'h3ff, 13'h1fff, "R6");
    step(1'b1, {10'h3ff, 3'b101}, 1'b1, 10'h3ff, 13'h0001, "R6");
    step(1'b1, {10'h3ff, 3'b000}, 1'b0, '0, '0, "R5");
    // R8: all low-bit patterns map to one entry.
    for (int k = 0; k < 8; k++)
      step(1'b1, {10'h200, 3'(k)}, 1'b0, '0, '0, "R8");
    // R4: alternate mode every sample.
    for (int k = 0; k < 16; k++)
      step(1'(k), DW'($urandom), 1'b0, '0, '0, "R4");
    flush();

    // Mid-run reset (R1), then constrained random traffic.
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic          en = 1'($urandom);
      logic [DW-1:0] d  = DW'($urandom);
      logic          we = ($urandom % 10) < 3;
      logic [AW-1:0] wa = ($urandom % 2 == 0) ? d[DW-1 -: AW] : AW'($urandom);
      string tag;
      if (!en) tag = "R3";
      else if (we && wa == d[DW-1 -: AW]) tag = "R6";
      else tag = "R2";
      step(en, d, we, wa, DW'($urandom), tag);
    end
    flush();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule